// File: doc/BRIEF.md
# Quadrature Encoder Position Timer

This peripheral turns the two phase outputs of an incremental encoder into a 16-bit up/down position count. Both phase inputs are synchronised to the core clock. Every legal change of either phase moves the count by one, in the direction given by the phase order. The count runs inside a window bounded by a programmable low value (the initial count) and a programmable high value (the modulus). Leaving the window at either end wraps the count to the other end and sets a sticky overflow flag. A programmable prescaler thins the rate at which decoded edges are accepted.

Software reaches the block through a single-cycle 32-bit register bus with a 3-bit word address. Writes are synchronous and reads are combinational. A set-only protection latch guards the configuration fields, and only a dedicated unlock bit in the mode word can clear it. A module-enable bit guards the window and counter registers. A write to the counter never stores the data written: it reloads the count from the initial-count register. Reads are never blocked.

Top module: `qdec_timer`

## Requirements
- R1: After reset, reads return count 0, initial count 0, modulus 0xFFFF, mode word 0 and protection word 0.
- R2: With module enable (mode word, address 0, bit 0) and quadrature enable (address 6, bit 0) both set and the prescaler at 0, each phase step through the order {A,B} = 00, 01, 11, 10 (and back to 00) increments the count by one.
- R3: Each phase step in the reverse order decrements the count by one.
- R4: A phase change in which A and B toggle together leaves the count unchanged.
- R5: Counting up from the modulus (address 3) loads the initial count (address 2). It also sets the sticky overflow flag (address 1, bit 1). Writing 1 to that bit clears the flag.
- R6: Counting down from the initial count loads the modulus and sets the overflow flag.
- R7: With prescaler value n (address 5, bits 2:0), a run of 2^n consecutive one-cycle phase steps moves the count by exactly one.
- R8: A write of any data to the counter (address 4) loads the initial count.
- R9: Writing 1 to address 1, bit 0, sets protection. Writing 0 there does not clear it. While protection is set, writes to the mode enable, initial count, modulus, prescaler and quadrature enable are ignored.
- R10: Writing 1 to address 0, bit 1, clears protection. This bit always reads 0.
- R11: While module enable is 0, writes to the initial count, modulus and counter are ignored.
- R12: While module enable or quadrature enable is 0, the count holds its value under any phase activity.
- R13: All fields, including the protection bit and the live count, can be read while protection is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |

## Verification
A wrong previous-phase register or a wrong direction decode shows up in the count word three clocks after the phase change that exposes it: two clocks of synchronisation and one of decode. It also builds up in later reads, because every step after the fault is offset by it. A wrong wrap boundary shows up as a count outside the window, and as a missing or spurious overflow flag, on the read after the crossing. A wrong protection or enable state is seen as soon as a guarded field is written and read back. A wrong prescaler divider phase is caught by counting accepted steps over bursts whose length is exactly one divider period.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [2:0] {
    A_MODE  = 3'd0,
    A_LOCK  = 3'd1,
    A_INIT  = 3'd2,
    A_MOD   = 3'd3,
    A_CNT   = 3'd4,
    A_PRESC = 3'd5,
    A_QUAD  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2,
    DIR_BAD  = 2'd3
  } step_dir_e;

  // position of a phase pair on the four-state ring 00,01,11,10
  function automatic logic [1:0] ring_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   ring_pos = 2'd0;
      2'b01:   ring_pos = 2'd1;
      2'b11:   ring_pos = 2'd2;
      default: ring_pos = 2'd3;
    endcase
  endfunction

  function automatic step_dir_e ring_dir(input logic [1:0] prev_ab,
                                         input logic [1:0] cur_ab);
    logic [1:0] d;
    d = ring_pos(cur_ab) - ring_pos(prev_ab);
    case (d)
      2'd1:    ring_dir = DIR_UP;
      2'd3:    ring_dir = DIR_DN;
      2'd2:    ring_dir = DIR_BAD;
      default: ring_dir = DIR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      dout <= '0;
    end else begin
      meta <= din;
      dout <= meta;
    end
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  output logic       step_up,
  output logic       step_dn
);
  logic [1:0] prev_ab;
  logic       prev_vld;
  step_dir_e  dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ab  <= 2'b00;
      prev_vld <= 1'b0;
    end else begin
      prev_ab  <= ab;
      prev_vld <= 1'b1;
    end
  end

  always_comb begin
    dir     = ring_dir(prev_ab, ab);
    step_up = prev_vld && (dir == DIR_UP);
    step_dn = prev_vld && (dir == DIR_DN);
  end
endmodule

// File: rtl/qdec_presc.sv
module qdec_presc #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [PS_W-1:0]  ps_q;
  logic [DIV_W-1:0] div;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
      div  <= '0;
    end else begin
      ps_q <= ps;
      if (ps != ps_q) div <= '0;
      else            div <= div + 1'b1;
    end
  end

  always_comb begin
    span = (DIV_W+1)'(1) << ps;
    mask = DIV_W'(span - 1'b1);
    tick = (ps == ps_q) && ((div & mask) == mask);
  end
endmodule

// File: rtl/qdec_core.sv
module qdec_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             load,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // returns {wrapped, next value}
  function automatic logic [CNT_W:0] next_val(input logic [CNT_W-1:0] c,
                                              input logic [CNT_W-1:0] l,
                                              input logic [CNT_W-1:0] h,
                                              input logic up,
                                              input logic dn);
    if (up) begin
      if (c == h) next_val = {1'b1, l};
      else        next_val = {1'b0, c + 1'b1};
    end else if (dn) begin
      if (c == l) next_val = {1'b1, h};
      else        next_val = {1'b0, c - 1'b1};
    end else begin
      next_val = {1'b0, c};
    end
  endfunction

  logic [CNT_W:0] nxt;

  always_comb begin
    nxt  = next_val(cnt, lo, hi, inc, dec);
    wrap = !load && nxt[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= lo;
    else           cnt <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              enc_a,
  input  logic              enc_b
);
  localparam logic [CNT_W-1:0] MOD_RST = '1;

  logic             protect, men, qen, ovf;
  logic [CNT_W-1:0] init_v, mod_v, cnt;
  logic [PS_W-1:0]  ps;
  logic [1:0]       ab_s;
  logic             step_up, step_dn, tick, run;
  logic             ev_up, ev_dn, wrap, cnt_load;
  logic             wr_mode, wr_lock, wr_init, wr_mod, wr_cnt, wr_ps, wr_quad;

  qdec_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_a, enc_b}), .dout(ab_s));

  qdec_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ab(ab_s), .step_up(step_up), .step_dn(step_dn));

  qdec_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .ps(ps), .tick(tick));

  always_comb begin
    wr_mode  = bus_we && (bus_addr == A_MODE);
    wr_lock  = bus_we && (bus_addr == A_LOCK);
    wr_init  = bus_we && (bus_addr == A_INIT);
    wr_mod   = bus_we && (bus_addr == A_MOD);
    wr_cnt   = bus_we && (bus_addr == A_CNT);
    wr_ps    = bus_we && (bus_addr == A_PRESC);
    wr_quad  = bus_we && (bus_addr == A_QUAD);
    cnt_load = wr_cnt && men;
    run      = men && qen && tick;
    ev_up    = run && step_up;
    ev_dn    = run && step_dn;
  end

  qdec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(ev_up), .dec(ev_dn), .load(cnt_load),
    .lo(init_v), .hi(mod_v), .cnt(cnt), .wrap(wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect <= 1'b0;
      men     <= 1'b0;
      qen     <= 1'b0;
      ovf     <= 1'b0;
      init_v  <= '0;
      mod_v   <= MOD_RST;
      ps      <= '0;
    end else begin
      if (wr_mode && bus_wdata[1])      protect <= 1'b0;
      else if (wr_lock && bus_wdata[0]) protect <= 1'b1;

      if (wr_mode && !protect) men <= bus_wdata[0];
      if (wr_quad && !protect) qen <= bus_wdata[0];
      if (wr_ps   && !protect) ps  <= bus_wdata[PS_W-1:0];
      if (wr_init && !protect && men) init_v <= bus_wdata[CNT_W-1:0];
      if (wr_mod  && !protect && men) mod_v  <= bus_wdata[CNT_W-1:0];

      if (wrap)                         ovf <= 1'b1;
      else if (wr_lock && bus_wdata[1]) ovf <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = DATA_W'(men);
      A_LOCK:  bus_rdata = DATA_W'({ovf, protect});
      A_INIT:  bus_rdata = DATA_W'(init_v);
      A_MOD:   bus_rdata = DATA_W'(mod_v);
      A_CNT:   bus_rdata = DATA_W'(cnt);
      A_PRESC: bus_rdata = DATA_W'(ps);
      A_QUAD:  bus_rdata = DATA_W'(qen);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdec_timer_chk.sv
module qdec_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             protect,
  input logic             men,
  input logic             qen,
  input logic             ovf,
  input logic             ev_up,
  input logic             ev_dn,
  input logic             cnt_load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_v,
  input logic [CNT_W-1:0] mod_v
);
  // R2
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up && !cnt_load && cnt != mod_v) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R3
  dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dn && !cnt_load && cnt != init_v) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_up && !cnt_load && cnt == mod_v) |=> (cnt == $past(init_v)) && ovf);

  // R6
  dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dn && !cnt_load && cnt == init_v && cnt != mod_v) |=> (cnt == $past(mod_v)) && ovf);

  // R9
  locked_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && bus_we && bus_addr == 3'd2) |=> $stable(init_v));

  // R10
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && bus_wdata[1]) |=> !protect);

  // R11
  off_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!men && bus_we && bus_addr == 3'd4) |=> $stable(cnt));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(men && qen) && !cnt_load) |=> $stable(cnt));
endmodule

bind qdec_timer qdec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .protect(protect), .men(men), .qen(qen), .ovf(ovf),
  .ev_up(ev_up), .ev_dn(ev_dn), .cnt_load(cnt_load), .cnt(cnt),
  .init_v(init_v), .mod_v(mod_v));

// File: tb/qdec_timer_test.sv
`timescale 1ns/1ps
module qdec_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        enc_a = 1'b0, enc_b = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0]  cur_ab = 2'b00;
  logic [15:0] exp_cnt, lo, hi;
  logic        exp_ovf;

  always #2.5 clk = ~clk;

  qdec_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b));

  // bench view: ring index i maps to {A,B} = {i[1], i[1]^i[0]}
  function automatic logic [1:0] idx_to_ab(input logic [1:0] i);
    return {i[1], i[1] ^ i[0]};
  endfunction
  function automatic logic [1:0] ab_to_idx(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction
  function automatic logic [16:0] model_move(input logic [15:0] c, input int dir,
                                             input logic [15:0] l, input logic [15:0] h);
    if (dir > 0) return (c == h) ? {1'b1, l} : {1'b0, c + 16'd1};
    if (dir < 0) return (c == l) ? {1'b1, h} : {1'b0, c - 16'd1};
    return {1'b0, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // dir: +1 up, -1 down, 2 both phases toggle, 0 hold
  task automatic move(input int dir, input int hold);
    logic [1:0] i;
    i = ab_to_idx(cur_ab);
    @(negedge clk);
    if (dir == 1)       cur_ab = idx_to_ab(i + 2'd1);
    else if (dir == -1) cur_ab = idx_to_ab(i - 2'd1);
    else if (dir == 2)  cur_ab = ~cur_ab;
    {enc_a, enc_b} = cur_ab;
    repeat (hold - 1) @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] r;
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset values
    rd_chk("R1 count", 3'd4, 32'h0);
    rd_chk("R1 init", 3'd2, 32'h0);
    rd_chk("R1 modulus", 3'd3, 32'hFFFF);
    rd_chk("R1 mode", 3'd0, 32'h0);
    rd_chk("R1 lock", 3'd1, 32'h0);

    // R11 guarded writes while module disabled
    wr(3'd2, 32'h7);
    wr(3'd3, 32'h5);
    rd_chk("R11 init ignored", 3'd2, 32'h0);
    rd_chk("R11 modulus ignored", 3'd3, 32'hFFFF);
    wr(3'd1, 32'h0); // harmless lock write, no bits
    wr(3'd0, 32'h1);
    wr(3'd6, 32'h1);
    move(1, 2); move(1, 2); settle();
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h1234);
    rd_chk("R11 counter write ignored", 3'd4, 32'h2);
    wr(3'd0, 32'h1);

    // R8 reload from initial count
    lo = 16'h10; hi = 16'h13;
    wr(3'd2, lo); wr(3'd3, hi);
    wr(3'd4, 32'hABCD);
    rd_chk("R8 reload", 3'd4, 32'h10);

    // R2 up and R5 wrap
    move(1, 2); move(1, 2); move(1, 2); settle();
    rd_chk("R2 up count", 3'd4, 32'h13);
    rd_chk("R5 no overflow yet", 3'd1, 32'h0);
    move(1, 2); settle();
    rd_chk("R5 wrap to init", 3'd4, 32'h10);
    rd_chk("R5 overflow set", 3'd1, 32'h2);
    wr(3'd1, 32'h2);
    rd_chk("R5 overflow cleared", 3'd1, 32'h0);

    // R6 down wrap, R3 down count
    move(-1, 2); settle();
    rd_chk("R6 wrap to modulus", 3'd4, 32'h13);
    rd_chk("R6 overflow set", 3'd1, 32'h2);
    wr(3'd1, 32'h2);
    move(-1, 2); move(-1, 2); settle();
    rd_chk("R3 down count", 3'd4, 32'h11);

    // R4 illegal transition
    move(2, 3); settle();
    rd_chk("R4 illegal ignored", 3'd4, 32'h11);
    move(1, 2); settle();
    rd_chk("R4 resumes from new phase", 3'd4, 32'h12);

    // R12 counting stops
    wr(3'd6, 32'h0);
    move(1, 2); move(1, 2); settle();
    rd_chk("R12 quad off holds", 3'd4, 32'h12);
    wr(3'd6, 32'h1);
    wr(3'd0, 32'h0);
    move(-1, 2); settle();
    rd_chk("R12 module off holds", 3'd4, 32'h12);
    wr(3'd0, 32'h1);

    // R9 protection, R13 reads under protection
    wr(3'd1, 32'h1);
    rd_chk("R13 lock readable", 3'd1, 32'h1);
    wr(3'd2, 32'h3);
    wr(3'd3, 32'h99);
    wr(3'd5, 32'h4);
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    rd_chk("R9 init locked", 3'd2, 32'h10);
    rd_chk("R9 modulus locked", 3'd3, 32'h13);
    rd_chk("R9 prescaler locked", 3'd5, 32'h0);
    rd_chk("R9 quad locked", 3'd6, 32'h1);
    rd_chk("R9 mode locked", 3'd0, 32'h1);
    rd_chk("R9 zero does not unlock", 3'd1, 32'h1);
    move(-1, 2); settle();
    rd_chk("R13 live count while locked", 3'd4, 32'h11);

    // R10 unlock
    wr(3'd0, 32'h3);
    rd_chk("R10 unlocked", 3'd1, 32'h0);
    rd_chk("R10 unlock bit reads zero", 3'd0, 32'h1);
    wr(3'd2, 32'h0);
    rd_chk("R10 init writable", 3'd2, 32'h0);

    // R7 prescaler
    wr(3'd3, 32'hFFFF);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h3);
    settle();
    for (int k = 0; k < 8; k++) move(1, 1);
    settle();
    rd_chk("R7 eight steps give one", 3'd4, 32'h1);
    for (int k = 0; k < 16; k++) move(1, 1);
    settle();
    rd_chk("R7 sixteen steps give two", 3'd4, 32'h3);
    wr(3'd5, 32'h1);
    settle();
    for (int k = 0; k < 4; k++) move(-1, 1);
    settle();
    rd_chk("R7 divide by two", 3'd4, 32'h1);
    wr(3'd5, 32'h0);

    // R2 R3 R4 R5 R6 random walk in a small window
    lo = 16'd5; hi = 16'd20;
    wr(3'd2, lo); wr(3'd3, hi); wr(3'd4, 32'h0);
    wr(3'd1, 32'h2);
    exp_cnt = lo; exp_ovf = 1'b0;
    for (int it = 1; it <= 400; it++) begin
      int sel, dir;
      sel = int'($urandom % 8);
      dir = (sel < 3) ? 1 : (sel < 6) ? -1 : (sel == 6) ? 2 : 0;
      move(dir, 1 + int'($urandom % 2));
      if (dir == 1 || dir == -1) begin
        r = model_move(exp_cnt, dir, lo, hi);
        exp_cnt = r[15:0];
        if (r[16]) exp_ovf = 1'b1;
      end
      if (it % 25 == 0) begin
        settle();
        rd_chk("R2 R3 R4 random walk count", 3'd4, {16'h0, exp_cnt});
        rd_chk("R5 R6 random walk overflow", 3'd1, {30'h0, exp_ovf, 1'b0});
        wr(3'd1, 32'h2);
        exp_ovf = 1'b0;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule